// File: doc/BRIEF.md
# System Management Interrupt Arbiter

This block collects system-management event sources into one registered, active-low interrupt line. The sources include thermal, legacy USB, software command, firmware release, a sleep-entry trap and an internal software timer. Each source has a sticky status bit and a matching mask bit in a 32-bit control word. The line goes low when three things hold at once: some enabled status is pending, the master enable is on, and the arbiter is armed.

The arbiter fires once for each handler episode. Firing clears the armed flag in hardware. The line then stays low until software writes the armed flag back to 1. After that write the line is held high for a fixed gap before it may fall again.

The block has two control outputs besides the interrupt line. Writing 1 to a write-only control bit sends out a one-clock notification pulse. A sleep-entry request is passed on to the sleep output unless the sleep-trap mask is set. When the mask is set, the request is turned into an interrupt instead.

Top module: `smi_arbiter`

## Requirements
- R1: After reset the control word reads 0x00000002 (only the armed flag at bit 1 is set). The status word reads 0, smi_no_o is 1, and sci_o and slp_req_o are 0.
- R2: In the control word, bits 10:8, 12, 16:15, 24:19 and 26 are reserved. They read 0 and ignore writes. Bit 7 always reads 0. Writing 0 to bit 1 has no effect.
- R3: While the master enable (control bit 0) is 0, smi_no_o stays 1 for any pending status.
- R4: When smi_no_o falls, the armed flag (control bit 1) reads 0 from the next cycle on.
- R5: Once smi_no_o is low, it stays low until software writes 1 to control bit 1, even if statuses are cleared or new ones arrive.
- R6: A re-arming write drives smi_no_o high on that clock edge. The line then stays high for 4 clocks before it can fall again.
- R7: Writing 1 to control bit 7 gives a single-cycle high pulse on sci_o in the cycle after the write.
- R8: If status bit 2 is already 1 when its mask (control bit 2) goes from 0 to 1, smi_no_o falls one clock after that write, provided the block is enabled and armed.
- R9: A sleep request while control bit 4 is 0 gives a one-cycle pulse on slp_req_o and leaves status bit 4 unchanged. While control bit 4 is 1, the same request sets status bit 4 and keeps slp_req_o at 0.
- R10: While control bit 6 is 1, the software timer sets status bit 6 every P clocks, and control bit 6 stays 1. The period P is 1, 16, 32 or 64 for rate_sel_i = 0, 1, 2, 3. Clearing control bit 6 before expiry resets the count, and no status results.
- R11: Status bits are sticky. A status write clears exactly the bits written as 1, and writes of 0 change nothing. An event pulse on evt_i[n] sets status bit n for the external source bits.
- R12: smi_no_o is a registered output. A pending event with an enabled, armed block makes it fall on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctl_we_i | input | 1 | Write strobe for the control word |
| sts_we_i | input | 1 | Write strobe for the status word (write 1 to clear) |
| rd_sts_i | input | 1 | Read select: 1 selects status, 0 selects control |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of the selected word |
| evt_i | input | 32 | Event pulses from the external sources |
| slp_wr_i | input | 1 | Pulse: a write is trying to enter sleep |
| rate_sel_i | input | 2 | Software timer period select |
| smi_no_o | output | 1 | Active-low management interrupt |
| sci_o | output | 1 | Notification pulse |
| slp_req_o | output | 1 | Forwarded sleep request pulse |

## Verification
A stuck or wrongly cleared armed flag shows at the ports in one of two ways. The interrupt line fails to fall one clock after a pending event, or it falls a second time within a single handler episode. A wrong gap counter shortens or lengthens the high window after re-arm, so the bench samples each of the four high clocks and the edge where the line falls. A timer off by one sets the status one clock early or late, and the bench samples it on the exact expiry clock.

// File: rtl/smi_arb_pkg.sv
package smi_arb_pkg;
  localparam int unsigned REG_W = 32;
  // writable mask bits plus master enable; armed flag handled separately
  localparam logic [REG_W-1:0] CTL_WR_MASK = 32'hFA06_687D;
  localparam logic [REG_W-1:0] CTL_RD_MASK = 32'hFA06_687F;
  localparam logic [REG_W-1:0] STS_MASK    = 32'hFA06_687C;
  // statuses set directly by external pulses (timer and sleep trap are internal)
  localparam logic [REG_W-1:0] EVT_MASK    = 32'hFA06_682C;
  localparam int unsigned GBL_BIT = 0;
  localparam int unsigned ARM_BIT = 1;
  localparam int unsigned SLP_BIT = 4;
  localparam int unsigned TMR_BIT = 6;
  localparam int unsigned SCI_BIT = 7;
endpackage

// File: rtl/smi_regs.sv
module smi_regs
  import smi_arb_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctl_we_i,
  input  logic             sts_we_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic [REG_W-1:0] evt_i,
  input  logic             tmr_hit_i,
  input  logic             slp_hit_i,
  input  logic             fire_i,
  output logic [REG_W-1:0] ctl_o,
  output logic [REG_W-1:0] sts_o,
  output logic             arm_set_o,
  output logic             pending_o
);
  logic [REG_W-1:0] ctl_q, sts_q, sts_set, sts_clr;
  logic             arm_q;

  assign arm_set_o = ctl_we_i & wdata_i[ARM_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctl_q <= '0;
    else if (ctl_we_i) ctl_q <= wdata_i & CTL_WR_MASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        arm_q <= 1'b1;
    else if (fire_i)    arm_q <= 1'b0;
    else if (arm_set_o) arm_q <= 1'b1;
  end

  always_comb begin
    sts_set = evt_i & EVT_MASK;
    sts_set[TMR_BIT] = tmr_hit_i;
    sts_set[SLP_BIT] = slp_hit_i;
    sts_clr = sts_we_i ? wdata_i : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_q <= '0;
    else         sts_q <= ((sts_q & ~sts_clr) | sts_set) & STS_MASK;
  end

  always_comb begin
    ctl_o = ctl_q;
    ctl_o[ARM_BIT] = arm_q;
  end
  assign sts_o     = sts_q;
  assign pending_o = |(sts_q & ctl_q & STS_MASK);

  AST_STS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sts_we_i |=> ((sts_q & $past(sts_q)) == $past(sts_q))); // R11
endmodule

// File: rtl/smi_swtimer.sv
module smi_swtimer #(
  parameter int unsigned PER0 = 1,
  parameter int unsigned PER1 = 16,
  parameter int unsigned PER2 = 32,
  parameter int unsigned PER3 = 64
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [1:0] rate_sel_i,
  output logic       hit_o
);
  localparam int unsigned PMAX01 = (PER0 > PER1) ? PER0 : PER1;
  localparam int unsigned PMAX23 = (PER2 > PER3) ? PER2 : PER3;
  localparam int unsigned PMAX   = (PMAX01 > PMAX23) ? PMAX01 : PMAX23;
  localparam int unsigned CNT_W  = (PMAX > 1) ? $clog2(PMAX) : 1;

  logic [CNT_W-1:0] cnt_q, lim;

  always_comb begin
    unique case (rate_sel_i)
      2'd0:    lim = CNT_W'(PER0 - 1);
      2'd1:    lim = CNT_W'(PER1 - 1);
      2'd2:    lim = CNT_W'(PER2 - 1);
      default: lim = CNT_W'(PER3 - 1);
    endcase
  end

  assign hit_o = en_i & (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (!en_i) cnt_q <= '0;
    else if (hit_o) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  AST_TMR_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_i) |-> !hit_o || (lim == '0)); // R10
endmodule

// File: rtl/smi_gate.sv
module smi_gate #(
  parameter int unsigned GAP_CLKS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gbl_i,
  input  logic arm_i,
  input  logic arm_set_i,
  input  logic pending_i,
  output logic fire_o,
  output logic smi_no_o
);
  localparam int unsigned GAP_W  = $clog2(GAP_CLKS + 1);
  localparam logic [GAP_W-1:0] GAP_LD = GAP_W'(GAP_CLKS - 1);

  logic [GAP_W-1:0] gap_q, hi_cnt_q;
  logic             smi_nq, rearm;

  assign rearm  = arm_set_i & ~arm_i;
  assign fire_o = smi_nq & arm_i & gbl_i & pending_i & (gap_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smi_nq <= 1'b1;
      gap_q  <= '0;
    end else if (rearm) begin
      smi_nq <= 1'b1;
      gap_q  <= GAP_LD;
    end else if (gap_q != '0) begin
      gap_q  <= gap_q - 1'b1;
    end else if (fire_o) begin
      smi_nq <= 1'b0;
    end
  end

  assign smi_no_o = smi_nq;

  // high-time tracker for the gap check only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        hi_cnt_q <= GAP_W'(GAP_CLKS);
    else if (!smi_nq)                   hi_cnt_q <= '0;
    else if (hi_cnt_q != GAP_W'(GAP_CLKS)) hi_cnt_q <= hi_cnt_q + 1'b1;
  end

  AST_NO_SMI_WO_GBL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gbl_i && smi_nq) |=> smi_nq); // R3
  AST_ARM_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(smi_nq) |-> !arm_i); // R4
  AST_HOLD_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!smi_nq && !arm_set_i) |=> !smi_nq); // R5
  AST_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(smi_nq) |-> (hi_cnt_q >= GAP_W'(GAP_CLKS - 1))); // R6
endmodule

// File: rtl/smi_arbiter.sv
module smi_arbiter
  import smi_arb_pkg::*;
#(
  parameter int unsigned GAP_CLKS = 4,
  parameter int unsigned TMR_PER0 = 1,
  parameter int unsigned TMR_PER1 = 16,
  parameter int unsigned TMR_PER2 = 32,
  parameter int unsigned TMR_PER3 = 64
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ctl_we_i,
  input  logic        sts_we_i,
  input  logic        rd_sts_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic [31:0] evt_i,
  input  logic        slp_wr_i,
  input  logic [1:0]  rate_sel_i,
  output logic        smi_no_o,
  output logic        sci_o,
  output logic        slp_req_o
);
  logic [REG_W-1:0] ctl, sts;
  logic tmr_hit, slp_hit, fire, arm_set, pending;
  logic sci_q, slp_q;

  assign slp_hit = slp_wr_i & ctl[SLP_BIT];

  smi_regs u_regs (
    .clk_i, .rst_ni, .ctl_we_i, .sts_we_i, .wdata_i, .evt_i,
    .tmr_hit_i (tmr_hit),
    .slp_hit_i (slp_hit),
    .fire_i    (fire),
    .ctl_o     (ctl),
    .sts_o     (sts),
    .arm_set_o (arm_set),
    .pending_o (pending)
  );

  smi_swtimer #(
    .PER0 (TMR_PER0), .PER1 (TMR_PER1), .PER2 (TMR_PER2), .PER3 (TMR_PER3)
  ) u_tmr (
    .clk_i, .rst_ni,
    .en_i       (ctl[TMR_BIT]),
    .rate_sel_i,
    .hit_o      (tmr_hit)
  );

  smi_gate #(.GAP_CLKS (GAP_CLKS)) u_gate (
    .clk_i, .rst_ni,
    .gbl_i     (ctl[GBL_BIT]),
    .arm_i     (ctl[ARM_BIT]),
    .arm_set_i (arm_set),
    .pending_i (pending),
    .fire_o    (fire),
    .smi_no_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sci_q <= 1'b0;
      slp_q <= 1'b0;
    end else begin
      sci_q <= ctl_we_i & wdata_i[SCI_BIT];
      slp_q <= slp_wr_i & ~ctl[SLP_BIT];
    end
  end

  assign sci_o     = sci_q;
  assign slp_req_o = slp_q;
  assign rdata_o   = rd_sts_i ? sts : (ctl & CTL_RD_MASK);

  AST_SLP_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slp_hit |=> !slp_q); // R9
endmodule

// File: tb/tb_smi_arbiter.sv
`timescale 1ns/1ps
module tb_smi_arbiter;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_we = 0, sts_we = 0, rd_sts = 0, slp_wr = 0;
  logic [31:0] wdata = '0, evt = '0, rdata;
  logic [1:0] rate = 2'd3;
  logic smi_n, sci, slp_req;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  smi_arbiter dut (
    .clk_i(clk), .rst_ni(rst_n), .ctl_we_i(ctl_we), .sts_we_i(sts_we),
    .rd_sts_i(rd_sts), .wdata_i(wdata), .rdata_o(rdata), .evt_i(evt),
    .slp_wr_i(slp_wr), .rate_sel_i(rate), .smi_no_o(smi_n), .sci_o(sci),
    .slp_req_o(slp_req)
  );

  // {write data, expected control readback}
  localparam logic [63:0] VEC [6] = '{
    {32'hFFFF_FFBE, 32'hFA06_683E},
    {32'h0000_0000, 32'h0000_0002},
    {32'h0000_0780, 32'h0000_0002},
    {32'h0500_1000, 32'h0000_0002},
    {32'hA5A5_A5A5, 32'hA004_2027},
    {32'h1234_5678, 32'h1204_407A}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr_ctl(input logic [31:0] d);
    @(negedge clk); ctl_we = 1; wdata = d;
    @(negedge clk); ctl_we = 0; wdata = '0;
  endtask

  task automatic wr_sts(input logic [31:0] d);
    @(negedge clk); sts_we = 1; wdata = d;
    @(negedge clk); sts_we = 0; wdata = '0;
  endtask

  task automatic pulse_evt(input logic [31:0] d);
    @(negedge clk); evt = d;
    @(negedge clk); evt = '0;
  endtask

  task automatic rd(input logic s, output logic [31:0] v);
    rd_sts = s; #1 v = rdata;
  endtask

  task automatic cleanup();
    wr_ctl(32'h2);
    wr_sts(32'hFFFF_FFFF);
    repeat (6) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(0, v); chk("R1 ctl", v, 32'h2);
    rd(1, v); chk("R1 sts", v, 32'h0);
    chk("R1 smi", {31'b0, smi_n}, 1);
    chk("R1 sci/slp", {30'b0, sci, slp_req}, 0);

    // R2 control readback table
    for (int i = 0; i < 6; i++) begin
      wr_ctl(VEC[i][63:32]);
      rd(0, v); chk($sformatf("R2 vec%0d", i), v, VEC[i][31:0]);
      chk("R2 smi idle", {31'b0, smi_n}, 1);
    end
    cleanup();

    // R11 sticky status
    pulse_evt(32'h0000_0008);
    repeat (3) @(negedge clk);
    rd(1, v); chk("R11 set", v, 32'h8);
    wr_sts(32'h0);
    rd(1, v); chk("R11 zero write", v, 32'h8);
    wr_sts(32'h8);
    rd(1, v); chk("R11 clear", v, 32'h0);

    // R3 no SMI while master enable is off
    wr_ctl(32'h0000_000A);
    pulse_evt(32'h0000_0008);
    repeat (4) @(negedge clk);
    chk("R3 gbl off", {31'b0, smi_n}, 1);
    // R12 falls one edge after enabling
    wr_ctl(32'h0000_000B);
    chk("R12 not yet", {31'b0, smi_n}, 1);
    @(negedge clk);
    chk("R12 fired", {31'b0, smi_n}, 0);
    rd(0, v); chk("R4 arm cleared", {31'b0, v[1]}, 0);

    // R5 stays low without re-arm
    wr_sts(32'h8);
    repeat (3) @(negedge clk);
    chk("R5 low after clear", {31'b0, smi_n}, 0);
    pulse_evt(32'h0000_0008);
    repeat (5) @(negedge clk);
    chk("R5 low no rearm", {31'b0, smi_n}, 0);

    // R6 re-arm gap
    wr_ctl(32'h0000_000B);
    chk("R6 gap1", {31'b0, smi_n}, 1);
    @(negedge clk); chk("R6 gap2", {31'b0, smi_n}, 1);
    @(negedge clk); chk("R6 gap3", {31'b0, smi_n}, 1);
    @(negedge clk); chk("R6 gap4", {31'b0, smi_n}, 1);
    @(negedge clk); chk("R6 refire", {31'b0, smi_n}, 0);
    cleanup();
    chk("R6 idle after cleanup", {31'b0, smi_n}, 1);

    // R7 notification pulse
    wr_ctl(32'h0000_0082);
    chk("R7 pulse", {31'b0, sci}, 1);
    @(negedge clk); chk("R7 single", {31'b0, sci}, 0);

    // R8 mask rising with status already set
    wr_ctl(32'h0000_0003);
    pulse_evt(32'h0000_0004);
    repeat (3) @(negedge clk);
    chk("R8 masked", {31'b0, smi_n}, 1);
    wr_ctl(32'h0000_0007);
    @(negedge clk); chk("R8 fire on mask", {31'b0, smi_n}, 0);
    cleanup();

    // R9 sleep forwarding and trapping
    wr_ctl(32'h0000_0003);
    @(negedge clk); slp_wr = 1;
    @(negedge clk); slp_wr = 0;
    chk("R9 forward", {31'b0, slp_req}, 1);
    rd(1, v); chk("R9 no status", {31'b0, v[4]}, 0);
    @(negedge clk); chk("R9 pulse ends", {31'b0, slp_req}, 0);
    wr_ctl(32'h0000_0013);
    @(negedge clk); slp_wr = 1;
    @(negedge clk); slp_wr = 0;
    chk("R9 trapped", {31'b0, slp_req}, 0);
    rd(1, v); chk("R9 status", {31'b0, v[4]}, 1);
    @(negedge clk); chk("R9 smi", {31'b0, smi_n}, 0);
    cleanup();

    // R10 timer period 16
    rate = 2'd1;
    wr_ctl(32'h0000_0043);
    repeat (15) @(negedge clk);
    rd(1, v); chk("R10 before expiry", {31'b0, v[6]}, 0);
    chk("R10 smi before", {31'b0, smi_n}, 1);
    @(negedge clk);
    rd(1, v); chk("R10 expiry", {31'b0, v[6]}, 1);
    @(negedge clk); chk("R10 smi", {31'b0, smi_n}, 0);
    rd(0, v); chk("R10 enable kept", {31'b0, v[6]}, 1);
    cleanup();

    // R10 cancel before expiry
    wr_ctl(32'h0000_0042);
    repeat (10) @(negedge clk);
    wr_ctl(32'h0000_0002);
    wr_ctl(32'h0000_0042);
    repeat (10) @(negedge clk);
    rd(1, v); chk("R10 cancel reset count", {31'b0, v[6]}, 0);
    wr_ctl(32'h0000_0002);
    repeat (30) @(negedge clk);
    rd(1, v); chk("R10 cancel no status", {31'b0, v[6]}, 0);

    // R10 period 1
    rate = 2'd0;
    wr_ctl(32'h0000_0042);
    @(negedge clk);
    rd(1, v); chk("R10 period1", {31'b0, v[6]}, 1);
    cleanup();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule